// File: doc/BRIEF.md
# Timer Channel Host Byte Port

This block is the host-side data path of one channel of a programmable interval timer. The host bus is one byte wide. The block turns single-byte data writes into the channel's 16-bit count register, using the access mode the channel is programmed with. It answers single-byte reads from one of three sources: the live count, a frozen snapshot of the count, or a frozen status byte. It also keeps the flag that says a new count has not yet reached the counting element, and the flip-flop that selects which half of the count the next two-byte access uses.

The counting engine and the address decode sit outside the block. They supply the live count, the output level, the programmed mode, access and BCD fields, and single-cycle strobes for control writes, latch commands and count transfers. Read data is combinational from the current state. A read strobe consumes the presented byte at the clock edge.

Top module: `tmr_chan_hostio`

## Requirements
- R1: With access code 1 (low only), a data write puts the byte in count bits 7:0 and zeroes bits 15:8. The count register and a one-cycle count-written pulse appear on the clock edge after the write.
- R2: With access code 2 (high only), a data write puts the byte in count bits 15:8 and zeroes bits 7:0. The count-written pulse has the same timing as in R1.
- R3: With access code 3 (low then high), the first write is held aside and changes neither the count register nor the pulse. The second write loads {second byte, first byte} and pulses count-written. Writes with access code 0 are ignored.
- R4: The null-count flag is 1 after reset. Every completed count write and every control write set it. A transfer strobe clears it, unless a write completes in the same cycle.
- R5: A control write zeroes the count register, discards a held low byte and resets the read half-selector to low. A data write in the same cycle is ignored.
- R6: A status latch captures, in one byte, bit 0 = BCD, bits 3:1 = mode, bits 5:4 = access code, bit 6 = null-count flag, bit 7 = output level. The next read returns this byte and discards it.
- R7: While a status byte is held, reads return it ahead of any latched or live count, and the half-selector does not move.
- R8: A count latch freezes the live count. A further count or status latch request is ignored while a latch of the same kind is still unread.
- R9: With access code 1 or 2, a read returns the low or the high byte of the latched count if one is held, otherwise of the live count. One such read releases the latch.
- R10: With access code 3, count reads alternate low byte then high byte. A latched count is released only when its high byte is read.
- R11: A latch request in the same cycle as a read leaves that read returning the data held before the cycle. The request takes effect only if no latch of its kind was held at the start of that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr | input | 1 | Pulse: control write that selects a new mode |
| ctl_acc | input | 2 | Programmed access code (1 low, 2 high, 3 low then high) |
| ctl_mode | input | 3 | Programmed counting mode, reported in status |
| ctl_bcd | input | 1 | Programmed BCD flag, reported in status |
| wr_en | input | 1 | Pulse: host data write |
| wr_data | input | 8 | Host write byte |
| rd_en | input | 1 | Pulse: host data read consumes rd_data |
| rd_data | output | 8 | Byte presented to the host |
| latch_cnt | input | 1 | Pulse: count latch request |
| latch_sts | input | 1 | Pulse: status latch request |
| cnt_val | input | 16 | Live count from the counting element |
| out_lvl | input | 1 | Channel output level |
| load_ack | input | 1 | Pulse: count register transferred into the counting element |
| cnt_reg | output | 16 | Assembled count register |
| cnt_written | output | 1 | Pulse: a complete count was written |
| null_cnt | output | 1 | Null-count flag |

## Verification
The hardest situations to reach are overlaps. A status latch and a count latch can both be held while a two-byte read is half done. A latch request can coincide with the read that releases an older latch. A control write can land between the two bytes of a write or a read. Directed sequences build the first overlaps on purpose. A long random run with a fixed seed then fires every strobe with independent probabilities, and changes access codes only through control writes, so that such coincidences recur many times. Every read byte and every register value is compared with a cycle model in the bench.

// File: rtl/hio_pkg.sv
`timescale 1ns/1ps
package hio_pkg;
    localparam int ACC_W  = 2;
    localparam int MODE_W = 3;
    localparam int STS_W  = 1 + MODE_W + ACC_W + 2;

    typedef enum logic [ACC_W-1:0] {
        ACC_LATCH = 2'd0,
        ACC_LO    = 2'd1,
        ACC_HI    = 2'd2,
        ACC_LOHI  = 2'd3
    } acc_e;

    // bit 7 output, bit 6 null, bits 5:4 access, bits 3:1 mode, bit 0 bcd
    function automatic logic [STS_W-1:0] pack_status(
        input logic              out_lvl,
        input logic              nul,
        input logic [ACC_W-1:0]  acc,
        input logic [MODE_W-1:0] mode,
        input logic              bcd
    );
        return {out_lvl, nul, acc, mode, bcd};
    endfunction
endpackage

// File: rtl/hio_wr_asm.sv
`timescale 1ns/1ps
module hio_wr_asm
    import hio_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ctl_wr,
    input  logic [ACC_W-1:0]    acc,
    input  logic                wr_en,
    input  logic [BYTE_W-1:0]   wr_data,
    input  logic                load_ack,
    output logic [2*BYTE_W-1:0] cnt_reg,
    output logic                cnt_written,
    output logic                null_cnt
);
    localparam int CNT_W = 2 * BYTE_W;

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic [BYTE_W-1:0] lo;
        logic              lo_pend;
        logic              written;
        logic              nul;
    } wst_t;

    wst_t st_d, st_q;
    logic done;

    always_comb begin
        st_d         = st_q;
        st_d.written = 1'b0;
        done         = 1'b0;
        if (ctl_wr) begin
            st_d.cnt     = '0;
            st_d.lo_pend = 1'b0;
            st_d.nul     = 1'b1;
        end else begin
            if (wr_en) begin
                case (acc_e'(acc))
                    ACC_LO: begin
                        st_d.cnt = {{BYTE_W{1'b0}}, wr_data};
                        done     = 1'b1;
                    end
                    ACC_HI: begin
                        st_d.cnt = {wr_data, {BYTE_W{1'b0}}};
                        done     = 1'b1;
                    end
                    ACC_LOHI: begin
                        if (st_q.lo_pend) begin
                            st_d.cnt     = {wr_data, st_q.lo};
                            st_d.lo_pend = 1'b0;
                            done         = 1'b1;
                        end else begin
                            st_d.lo      = wr_data;
                            st_d.lo_pend = 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
            if (done) begin
                st_d.written = 1'b1;
                st_d.nul     = 1'b1;
            end else if (load_ack) begin
                st_d.nul = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{cnt: '0, lo: '0, lo_pend: 1'b0, written: 1'b0, nul: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_reg     = st_q.cnt;
    assign cnt_written = st_q.written;
    assign null_cnt    = st_q.nul;
endmodule

// File: rtl/hio_latch.sv
`timescale 1ns/1ps
module hio_latch #(
    parameter int BYTE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                latch_cnt,
    input  logic                latch_sts,
    input  logic [2*BYTE_W-1:0] cnt_val,
    input  logic [BYTE_W-1:0]   sts_byte,
    input  logic                cnt_rel,
    input  logic                sts_rel,
    output logic                cnt_lat_v,
    output logic [2*BYTE_W-1:0] cnt_lat,
    output logic                sts_lat_v,
    output logic [BYTE_W-1:0]   sts_lat
);
    localparam int CNT_W = 2 * BYTE_W;

    typedef struct packed {
        logic              cv;
        logic [CNT_W-1:0]  cl;
        logic              sv;
        logic [BYTE_W-1:0] sl;
    } lst_t;

    lst_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cnt_rel) st_d.cv = 1'b0;
        if (sts_rel) st_d.sv = 1'b0;
        // a request is honoured only if nothing of its kind is held
        if (latch_cnt && !st_q.cv) begin
            st_d.cv = 1'b1;
            st_d.cl = cnt_val;
        end
        if (latch_sts && !st_q.sv) begin
            st_d.sv = 1'b1;
            st_d.sl = sts_byte;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_lat_v = st_q.cv;
    assign cnt_lat   = st_q.cl;
    assign sts_lat_v = st_q.sv;
    assign sts_lat   = st_q.sl;
endmodule

// File: rtl/hio_rd_sel.sv
`timescale 1ns/1ps
module hio_rd_sel
    import hio_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ctl_wr,
    input  logic [ACC_W-1:0]    acc,
    input  logic                rd_en,
    input  logic                sts_lat_v,
    input  logic [BYTE_W-1:0]   sts_lat,
    input  logic                cnt_lat_v,
    input  logic [2*BYTE_W-1:0] cnt_lat,
    input  logic [2*BYTE_W-1:0] cnt_val,
    output logic [BYTE_W-1:0]   rd_data,
    output logic                cnt_rel,
    output logic                sts_rel
);
    localparam int CNT_W  = 2 * BYTE_W;
    localparam int N_LANE = CNT_W / BYTE_W;

    typedef struct packed {
        logic hi_next;
    } rst_t;

    rst_t st_d, st_q;
    logic [CNT_W-1:0]  src;
    logic [BYTE_W-1:0] lane [N_LANE];
    logic [BYTE_W-1:0] cnt_byte;
    logic              cnt_rd;

    assign src = cnt_lat_v ? cnt_lat : cnt_val;

    for (genvar g = 0; g < N_LANE; g++) begin : g_lane
        assign lane[g] = src[g*BYTE_W +: BYTE_W];
    end

    always_comb begin
        case (acc_e'(acc))
            ACC_HI:   cnt_byte = lane[1];
            ACC_LOHI: cnt_byte = st_q.hi_next ? lane[1] : lane[0];
            default:  cnt_byte = lane[0];
        endcase
        rd_data = sts_lat_v ? sts_lat : cnt_byte;
        cnt_rd  = rd_en && !sts_lat_v;
        sts_rel = rd_en && sts_lat_v;
        cnt_rel = cnt_rd && cnt_lat_v &&
                  ((acc_e'(acc) != ACC_LOHI) || st_q.hi_next);
        st_d = st_q;
        if (cnt_rd && acc_e'(acc) == ACC_LOHI) st_d.hi_next = !st_q.hi_next;
        if (ctl_wr) st_d.hi_next = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/tmr_chan_hostio.sv
`timescale 1ns/1ps
module tmr_chan_hostio
    import hio_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ctl_wr,
    input  logic [1:0]          ctl_acc,
    input  logic [2:0]          ctl_mode,
    input  logic                ctl_bcd,
    input  logic                wr_en,
    input  logic [BYTE_W-1:0]   wr_data,
    input  logic                rd_en,
    output logic [BYTE_W-1:0]   rd_data,
    input  logic                latch_cnt,
    input  logic                latch_sts,
    input  logic [2*BYTE_W-1:0] cnt_val,
    input  logic                out_lvl,
    input  logic                load_ack,
    output logic [2*BYTE_W-1:0] cnt_reg,
    output logic                cnt_written,
    output logic                null_cnt
);
    localparam int CNT_W = 2 * BYTE_W;

    logic [BYTE_W-1:0] sts_byte;
    logic              cnt_lat_v, sts_lat_v, cnt_rel, sts_rel;
    logic [CNT_W-1:0]  cnt_lat;
    logic [BYTE_W-1:0] sts_lat;

    assign sts_byte = BYTE_W'(pack_status(out_lvl, null_cnt, ctl_acc, ctl_mode, ctl_bcd));

    hio_wr_asm #(.BYTE_W(BYTE_W)) u_wr (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .acc(ctl_acc),
        .wr_en(wr_en), .wr_data(wr_data), .load_ack(load_ack),
        .cnt_reg(cnt_reg), .cnt_written(cnt_written), .null_cnt(null_cnt)
    );

    hio_latch #(.BYTE_W(BYTE_W)) u_lat (
        .clk(clk), .rst_n(rst_n), .latch_cnt(latch_cnt), .latch_sts(latch_sts),
        .cnt_val(cnt_val), .sts_byte(sts_byte), .cnt_rel(cnt_rel), .sts_rel(sts_rel),
        .cnt_lat_v(cnt_lat_v), .cnt_lat(cnt_lat), .sts_lat_v(sts_lat_v), .sts_lat(sts_lat)
    );

    hio_rd_sel #(.BYTE_W(BYTE_W)) u_rd (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .acc(ctl_acc), .rd_en(rd_en),
        .sts_lat_v(sts_lat_v), .sts_lat(sts_lat), .cnt_lat_v(cnt_lat_v),
        .cnt_lat(cnt_lat), .cnt_val(cnt_val), .rd_data(rd_data),
        .cnt_rel(cnt_rel), .sts_rel(sts_rel)
    );
endmodule

// File: rtl/hio_chk.sv
`timescale 1ns/1ps
module hio_chk #(
    parameter int BYTE_W = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                ctl_wr,
    input logic [1:0]          ctl_acc,
    input logic                wr_en,
    input logic [BYTE_W-1:0]   wr_data,
    input logic                load_ack,
    input logic [2*BYTE_W-1:0] cnt_reg,
    input logic                cnt_written,
    input logic                null_cnt
);
    // R4
    null_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_written |-> null_cnt);

    // R4
    null_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_ack && !wr_en && !ctl_wr) |=> !null_cnt);

    // R5
    ctl_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr |=> (cnt_reg == '0 && null_cnt && !cnt_written));

    // R1
    low_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !ctl_wr && ctl_acc == 2'd1) |=>
        (cnt_written && cnt_reg == {{BYTE_W{1'b0}}, $past(wr_data)}));

    // R2
    high_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !ctl_wr && ctl_acc == 2'd2) |=>
        (cnt_written && cnt_reg == {$past(wr_data), {BYTE_W{1'b0}}}));
endmodule

bind tmr_chan_hostio hio_chk #(.BYTE_W(BYTE_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_acc(ctl_acc),
    .wr_en(wr_en), .wr_data(wr_data), .load_ack(load_ack),
    .cnt_reg(cnt_reg), .cnt_written(cnt_written), .null_cnt(null_cnt)
);

// File: tb/tb_tmr_chan_hostio.sv
`timescale 1ns/1ps
module tb_tmr_chan_hostio;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctl_wr = 0, ctl_bcd = 0, wr_en = 0, rd_en = 0;
    logic        latch_cnt = 0, latch_sts = 0, out_lvl = 0, load_ack = 0;
    logic [1:0]  ctl_acc = 2'd1;
    logic [2:0]  ctl_mode = 3'd0;
    logic [7:0]  wr_data = 0;
    logic [15:0] cnt_val = 0;
    logic [7:0]  rd_data;
    logic [15:0] cnt_reg;
    logic        cnt_written, null_cnt;

    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    // reference state
    logic [15:0] m_cnt;  logic [7:0] m_lo; logic m_pend, m_wr, m_null;
    logic        m_cv;   logic [15:0] m_cl;
    logic        m_sv;   logic [7:0] m_sl;
    logic        m_hi;

    always #2.5 clk = ~clk;

    tmr_chan_hostio dut (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_acc(ctl_acc),
        .ctl_mode(ctl_mode), .ctl_bcd(ctl_bcd), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .latch_cnt(latch_cnt), .latch_sts(latch_sts),
        .cnt_val(cnt_val), .out_lvl(out_lvl), .load_ack(load_ack),
        .cnt_reg(cnt_reg), .cnt_written(cnt_written), .null_cnt(null_cnt)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] exp_rd();
        logic [15:0] s;
        if (m_sv) return m_sl;
        s = m_cv ? m_cl : cnt_val;
        case (ctl_acc)
            2'd2:    return s[15:8];
            2'd3:    return m_hi ? s[15:8] : s[7:0];
            default: return s[7:0];
        endcase
    endfunction

    task automatic model_reset();
        m_cnt = 0; m_lo = 0; m_pend = 0; m_wr = 0; m_null = 1;
        m_cv = 0; m_cl = 0; m_sv = 0; m_sl = 0; m_hi = 0;
    endtask

    task automatic model_step();
        logic done, ocv, osv, cnt_rd;
        logic [7:0] sts;
        done = 0; ocv = m_cv; osv = m_sv;
        sts = {out_lvl, m_null, ctl_acc, ctl_mode, ctl_bcd};
        cnt_rd = rd_en && !osv;
        if (rd_en && osv) m_sv = 0;
        if (cnt_rd && ocv && (ctl_acc != 2'd3 || m_hi)) m_cv = 0;
        if (cnt_rd && ctl_acc == 2'd3) m_hi = !m_hi;
        if (latch_cnt && !ocv) begin m_cv = 1; m_cl = cnt_val; end
        if (latch_sts && !osv) begin m_sv = 1; m_sl = sts; end
        m_wr = 0;
        if (ctl_wr) begin
            m_cnt = 0; m_pend = 0; m_null = 1; m_hi = 0;
        end else begin
            if (wr_en) begin
                if (ctl_acc == 2'd1) begin m_cnt = {8'h00, wr_data}; done = 1; end
                else if (ctl_acc == 2'd2) begin m_cnt = {wr_data, 8'h00}; done = 1; end
                else if (ctl_acc == 2'd3) begin
                    if (m_pend) begin m_cnt = {wr_data, m_lo}; m_pend = 0; done = 1; end
                    else begin m_lo = wr_data; m_pend = 1; end
                end
            end
            if (done) begin m_wr = 1; m_null = 1; end
            else if (load_ack) m_null = 0;
        end
    endtask

    // one cycle: inputs already driven at a falling edge
    task automatic cyc();
        string rt, wt;
        #1;
        if (rd_en) begin
            if (latch_cnt || latch_sts) rt = "R11";
            else if (m_sv) rt = m_cv ? "R7" : "R6";
            else if (ctl_acc == 2'd3) rt = "R10";
            else rt = m_cv ? "R8" : "R9";
            check(rt, rd_data, exp_rd());
        end
        @(posedge clk);
        model_step();
        @(negedge clk);
        if (ctl_wr) wt = "R5";
        else if (ctl_acc == 2'd3) wt = "R3";
        else if (ctl_acc == 2'd2) wt = "R2";
        else wt = "R1";
        check(wt, cnt_reg, m_cnt);
        check(wt, cnt_written, m_wr);
        check("R4", null_cnt, m_null);
        ctl_wr = 0; wr_en = 0; rd_en = 0; latch_cnt = 0; latch_sts = 0; load_ack = 0;
    endtask

    initial begin
        int unused;
        unused = $urandom(32'd4711);
        model_reset();
        repeat (3) @(negedge clk);
        // reset state
        check("R4", null_cnt, 1); check("R1", cnt_reg, 0); check("R1", cnt_written, 0);
        rst_n = 1;
        @(negedge clk);
        // R3 two-byte write
        ctl_wr = 1; ctl_acc = 3; ctl_mode = 3'd2; cyc();
        wr_en = 1; wr_data = 8'h34; cyc();
        wr_en = 1; wr_data = 8'h12; cyc();
        check("R3", cnt_reg, 16'h1234);
        load_ack = 1; cyc();
        // R8 repeat latch ignored, R10 release after high byte
        cnt_val = 16'hABCD; latch_cnt = 1; cyc();
        cnt_val = 16'h1111; latch_cnt = 1; cyc();
        rd_en = 1; cyc(); rd_en = 1; cyc(); rd_en = 1; cyc(); rd_en = 1; cyc();
        // R7 status ahead of count, R6 layout
        out_lvl = 1; ctl_bcd = 1; latch_cnt = 1; latch_sts = 1; cnt_val = 16'h5678; cyc();
        latch_sts = 1; out_lvl = 0; cyc();
        rd_en = 1; cyc(); rd_en = 1; cyc(); rd_en = 1; cyc();
        // R11 latch with read, R9 low/high only modes
        ctl_wr = 1; ctl_acc = 1; cyc();
        latch_cnt = 1; rd_en = 1; cnt_val = 16'h9A9B; cyc();
        cnt_val = 16'h0000; rd_en = 1; cyc(); rd_en = 1; cyc();
        ctl_wr = 1; ctl_acc = 2; cyc();
        wr_en = 1; wr_data = 8'hC3; latch_cnt = 1; cnt_val = 16'h7E01; cyc();
        rd_en = 1; latch_cnt = 1; cyc(); rd_en = 1; cyc();
        // R5 control write between the two bytes of a write
        ctl_wr = 1; ctl_acc = 3; cyc();
        wr_en = 1; wr_data = 8'h55; cyc();
        ctl_wr = 1; wr_en = 1; wr_data = 8'h66; cyc();
        wr_en = 1; wr_data = 8'h77; cyc();
        check("R5", cnt_reg, 16'h0000);
        // random phase
        for (int i = 0; i < 6000; i++) begin
            ctl_wr = ($urandom % 100) < 4;
            if (ctl_wr) begin
                ctl_acc = 2'(1 + $urandom % 3);
                ctl_mode = 3'($urandom); ctl_bcd = 1'($urandom);
            end
            wr_en = ($urandom % 100) < 30; wr_data = 8'($urandom);
            rd_en = ($urandom % 100) < 35;
            latch_cnt = ($urandom % 100) < 10;
            latch_sts = ($urandom % 100) < 8;
            load_ack = ($urandom % 100) < 10;
            out_lvl = 1'($urandom); cnt_val = 16'($urandom);
            cyc();
        end
        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end
endmodule